// File: doc/BRIEF.md
# Byte-Stream Command to Wishbone Master Bridge

This block lets a byte-serial link drive a memory-mapped bus. Command frames arrive on an 8-bit valid/ready input stream, with each frame closed by a last flag. A frame is either a read request or a write request. The bridge runs Wishbone classic cycles on a 32-bit data bus with per-byte selects. Each request may start at any byte address and may cover any byte count. When a request completes, the bridge sends a response frame on an 8-bit valid/ready output stream.

Both streams follow the usual rules. A byte moves only in a cycle where valid and ready are both high. Once the output stream raises valid, it keeps data and last unchanged until ready is seen high. The bridge lowers input ready whenever a bus cycle is in flight, and also while a response is being produced. This lets the command source stall as long as it likes and lets the response sink push back at any time. Frames that start with an unknown byte are skipped whole. Bytes that follow a complete request are discarded. A frame that ends early is dropped without a reply.

Top module: `bwb_bridge`

## Requirements
- R1: A request frame is laid out in this order:
  - one opcode byte, 0xA1 for read or 0xA2 for write;
  - a 32-bit byte address, most significant byte first;
  - a 16-bit byte count, most significant byte first;
  - for a write only, exactly count data bytes in ascending address order.
- R2: After a write finishes, the response is 0xA4 followed by the echoed 4 address bytes and 2 count bytes. Last is set on the final byte.
- R3: After a read, the response is 0xA3, then the echoed address and count, then the requested bytes in ascending address order. Last is set on the final data byte.
- R4: The bus word address is byte address bits [31:2]. The byte at a byte address whose two low bits equal k travels on data bits [8k+7:8k] and uses select bit k.
- R5: A write issues one bus cycle for each 32-bit word it touches. Each cycle asserts only the select bits of bytes inside the range, so memory bytes outside the range keep their values.
- R6: A read issues one bus cycle for each word it touches. Across the whole read, the number of asserted select bits equals the byte count.
- R7: A frame whose first byte is not 0xA1 or 0xA2 is ignored through its last byte. This includes leading zero bytes and response opcodes. Such a frame causes no bus cycle and no response.
- R8: Bytes after a complete request, up to the last flag, are discarded. The request still runs and still produces its normal response.
- R9: If the last flag arrives before the header is complete, or before all write data owed has arrived, the frame is aborted with no response. The word holding the byte marked last is not written. Words already written stay written.
- R10: A request with count 0 makes no bus cycle. It returns only its 7-byte response header, with last on the final count byte.
- R11: Busy behaves as follows:
  - it is low after reset;
  - it is high from the cycle after a valid opcode is accepted until the last response byte has been accepted;
  - it is high whenever output valid is high.
- R12: While cyc is high, input ready is low and stb equals cyc. Address, data, selects and write enable stay unchanged until ack.
- R13: While output valid is high and output ready is low, valid, data and last hold in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_data | input | 8 | Command stream byte |
| cmd_valid | input | 1 | Command byte valid |
| cmd_last | input | 1 | Command byte ends its frame |
| cmd_ready | output | 1 | Bridge accepts a command byte |
| rsp_data | output | 8 | Response stream byte |
| rsp_valid | output | 1 | Response byte valid |
| rsp_last | output | 1 | Response byte ends its frame |
| rsp_ready | input | 1 | Sink accepts a response byte |
| wb_adr | output | 30 | Bus word address |
| wb_dat_o | output | 32 | Write data |
| wb_dat_i | input | 32 | Read data |
| wb_we | output | 1 | Write enable |
| wb_sel | output | 4 | Byte selects |
| wb_stb | output | 1 | Strobe |
| wb_cyc | output | 1 | Cycle |
| wb_ack | input | 1 | Cycle acknowledge |
| busy | output | 1 | Request in progress |

## Verification
The core of the test is a sweep of every start lane from 0 to 3 against every count from 1 to 9, run first as writes and then as reads over a guarded memory image. This sweep separates ranges that fit inside one word, ranges that cross one boundary, and ranges that cross two, and it shows whether the edge selects are wrong on either side. Response back-pressure follows a pseudo-random pattern, so that stalls land on header bytes and on data bytes alike. The remaining frames each target one parser path and show whether the bridge skips, executes or aborts: leading zeros, a response opcode used as a request, trailing padding, truncation in the header, truncation in the write data, and zero counts.

// File: rtl/bwb_pkg.sv
package bwb_pkg;
  localparam logic [7:0] OP_RD_REQ = 8'hA1;
  localparam logic [7:0] OP_WR_REQ = 8'hA2;
  localparam logic [7:0] OP_RD_RSP = 8'hA3;
  localparam logic [7:0] OP_WR_RSP = 8'hA4;

  typedef enum logic [2:0] {
    ST_IDLE,    // waiting for an opcode byte
    ST_HDR,     // collecting address and count
    ST_WDATA,   // collecting write bytes into the word buffer
    ST_WBUS,    // write cycle outstanding
    ST_RHDR,    // sending response header
    ST_RBUS,    // read cycle outstanding
    ST_RSHIFT,  // sending read bytes of the captured word
    ST_SKIP     // discarding bytes up to the frame end
  } bwb_state_e;
endpackage

// File: rtl/bwb_lane_mask.sv
module bwb_lane_mask #(
  parameter int LANES = 4,
  parameter int CNT_W = 16,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic [LANE_W-1:0] start,
  input  logic [CNT_W-1:0]  remaining,
  output logic [LANES-1:0]  mask
);
  // lane g is selected when it lies at or above the start lane and
  // within the bytes still owed
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mask[g] = (32'(start) <= 32'(g)) &&
                     (32'(remaining) > (32'(g) - 32'(start)));
  end
endmodule

// File: rtl/bwb_rsp_reg.sv
module bwb_rsp_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         push_last,
  output logic         room,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         out_last,
  input  logic         out_ready
);
  assign room = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (push) begin
      out_valid <= 1'b1;
      out_data  <= push_data;
      out_last  <= push_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bwb_bridge.sv
module bwb_bridge #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  localparam int LANES    = DATA_W / 8,
  localparam int LANE_W   = $clog2(LANES),
  localparam int WB_ADR_W = ADDR_W - LANE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [7:0]          cmd_data,
  input  logic                cmd_valid,
  input  logic                cmd_last,
  output logic                cmd_ready,
  output logic [7:0]          rsp_data,
  output logic                rsp_valid,
  output logic                rsp_last,
  input  logic                rsp_ready,
  output logic [WB_ADR_W-1:0] wb_adr,
  output logic [DATA_W-1:0]   wb_dat_o,
  input  logic [DATA_W-1:0]   wb_dat_i,
  output logic                wb_we,
  output logic [LANES-1:0]    wb_sel,
  output logic                wb_stb,
  output logic                wb_cyc,
  input  logic                wb_ack,
  output logic                busy
);
  import bwb_pkg::*;

  localparam int HDR_W     = ADDR_W + CNT_W;
  localparam int HDR_BYTES = HDR_W / 8;
  localparam int IDX_W     = $clog2(HDR_BYTES + 1);

  bwb_state_e          state;
  logic [IDX_W-1:0]    hdr_idx;
  logic [IDX_W-1:0]    rsp_idx;
  logic [HDR_W-9:0]    hdr_sr;
  logic [HDR_W-1:0]    hdr_full;
  logic [HDR_W-1:0]    echo_sr;
  logic                is_write;
  logic                cnt_zero;
  logic                seen_last;
  logic [ADDR_W-1:0]   addr;
  logic [CNT_W-1:0]    count;
  logic [WB_ADR_W-1:0] adr_q;
  logic [DATA_W-1:0]   wbuf;
  logic [LANES-1:0]    wsel;
  logic [DATA_W-1:0]   rbuf;
  logic [LANES-1:0]    rd_mask;
  logic [LANE_W-1:0]   lane;
  logic                beat;
  logic                room;
  logic                push;
  logic [7:0]          push_data;
  logic                push_last;
  logic                last_lane;
  logic                final_byte;

  assign lane       = addr[LANE_W-1:0];
  assign last_lane  = (lane == LANE_W'(LANES - 1));
  assign final_byte = (count == CNT_W'(1));
  assign hdr_full   = {hdr_sr, cmd_data};
  assign beat       = cmd_valid && cmd_ready;

  bwb_lane_mask #(.LANES(LANES), .CNT_W(CNT_W)) u_mask (
    .start     (lane),
    .remaining (count),
    .mask      (rd_mask)
  );

  bwb_rsp_reg #(.W(8)) u_rsp (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_data (push_data),
    .push_last (push_last),
    .room      (room),
    .out_valid (rsp_valid),
    .out_data  (rsp_data),
    .out_last  (rsp_last),
    .out_ready (rsp_ready)
  );

  // stream and bus outputs
  always_comb begin
    cmd_ready = (state == ST_IDLE) || (state == ST_HDR) ||
                (state == ST_WDATA) || (state == ST_SKIP);
    wb_cyc    = (state == ST_WBUS) || (state == ST_RBUS);
    wb_stb    = wb_cyc;
    wb_we     = (state == ST_WBUS);
    wb_sel    = (state == ST_WBUS) ? wsel :
                (state == ST_RBUS) ? rd_mask : '0;
    wb_adr    = adr_q;
    wb_dat_o  = wbuf;
    busy      = ((state != ST_IDLE) && (state != ST_SKIP)) || rsp_valid;

    push      = 1'b0;
    push_data = 8'h00;
    push_last = 1'b0;
    if (state == ST_RHDR) begin
      push      = room;
      push_data = (rsp_idx == '0) ? (is_write ? OP_WR_RSP : OP_RD_RSP)
                                  : echo_sr[HDR_W-1 -: 8];
      push_last = (rsp_idx == IDX_W'(HDR_BYTES)) && (is_write || cnt_zero);
    end else if (state == ST_RSHIFT) begin
      push      = room;
      push_data = rbuf[8*lane +: 8];
      push_last = final_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      hdr_idx   <= '0;
      rsp_idx   <= '0;
      hdr_sr    <= '0;
      echo_sr   <= '0;
      is_write  <= 1'b0;
      cnt_zero  <= 1'b0;
      seen_last <= 1'b0;
      addr      <= '0;
      count     <= '0;
      adr_q     <= '0;
      wbuf      <= '0;
      wsel      <= '0;
      rbuf      <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (beat) begin
            if ((cmd_data == OP_RD_REQ) || (cmd_data == OP_WR_REQ)) begin
              is_write <= (cmd_data == OP_WR_REQ);
              hdr_idx  <= '0;
              if (!cmd_last) state <= ST_HDR;
            end else if (!cmd_last) begin
              state <= ST_SKIP;
            end
          end
        end

        ST_HDR: begin
          if (beat) begin
            hdr_sr  <= hdr_full[HDR_W-9:0];
            hdr_idx <= hdr_idx + 1'b1;
            if (hdr_idx == IDX_W'(HDR_BYTES - 1)) begin
              addr      <= hdr_full[HDR_W-1:CNT_W];
              count     <= hdr_full[CNT_W-1:0];
              echo_sr   <= hdr_full;
              cnt_zero  <= (hdr_full[CNT_W-1:0] == '0);
              seen_last <= cmd_last;
              rsp_idx   <= '0;
              wsel      <= '0;
              if (is_write && (hdr_full[CNT_W-1:0] != '0))
                state <= cmd_last ? ST_IDLE : ST_WDATA;
              else
                state <= ST_RHDR;
            end else if (cmd_last) begin
              state <= ST_IDLE;
            end
          end
        end

        ST_WDATA: begin
          if (beat) begin
            wbuf[8*lane +: 8] <= cmd_data;
            wsel[lane]        <= 1'b1;
            addr              <= addr + 1'b1;
            count             <= count - 1'b1;
            if (last_lane || final_byte) begin
              adr_q <= addr[ADDR_W-1:LANE_W];
              if (cmd_last && !final_byte) begin
                state <= ST_IDLE;
              end else begin
                seen_last <= cmd_last;
                state     <= ST_WBUS;
              end
            end else if (cmd_last) begin
              state <= ST_IDLE;
            end
          end
        end

        ST_WBUS: begin
          if (wb_ack) begin
            wsel  <= '0;
            state <= (count == '0) ? ST_RHDR : ST_WDATA;
          end
        end

        ST_RHDR: begin
          if (room) begin
            rsp_idx <= rsp_idx + 1'b1;
            if (rsp_idx != '0) echo_sr <= echo_sr << 8;
            if (rsp_idx == IDX_W'(HDR_BYTES)) begin
              if (is_write || cnt_zero) begin
                state <= seen_last ? ST_IDLE : ST_SKIP;
              end else begin
                adr_q <= addr[ADDR_W-1:LANE_W];
                state <= ST_RBUS;
              end
            end
          end
        end

        ST_RBUS: begin
          if (wb_ack) begin
            rbuf  <= wb_dat_i;
            state <= ST_RSHIFT;
          end
        end

        ST_RSHIFT: begin
          if (room) begin
            addr  <= addr + 1'b1;
            count <= count - 1'b1;
            if (final_byte) begin
              state <= seen_last ? ST_IDLE : ST_SKIP;
            end else if (last_lane) begin
              adr_q <= addr[ADDR_W-1:LANE_W] + 1'b1;
              state <= ST_RBUS;
            end
          end
        end

        ST_SKIP: begin
          if (beat && cmd_last) state <= ST_IDLE;
        end

        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bwb_bridge_chk.sv
module bwb_bridge_chk #(
  parameter int WB_ADR_W = 30,
  parameter int DATA_W   = 32,
  parameter int LANES    = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                cmd_ready,
  input logic [7:0]          rsp_data,
  input logic                rsp_valid,
  input logic                rsp_last,
  input logic                rsp_ready,
  input logic [WB_ADR_W-1:0] wb_adr,
  input logic [DATA_W-1:0]   wb_dat_o,
  input logic                wb_we,
  input logic [LANES-1:0]    wb_sel,
  input logic                wb_stb,
  input logic                wb_cyc,
  input logic                wb_ack,
  input logic                busy
);
  p_rsp_hold_r13: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_last)));

  p_cyc_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc && !wb_ack) |=> (wb_cyc && $stable(wb_adr) && $stable(wb_we) &&
                             $stable(wb_sel) && $stable(wb_dat_o)));

  p_stb_cyc_r12: assert property (@(posedge clk) disable iff (rst)
    wb_stb == wb_cyc);

  p_no_accept_r12: assert property (@(posedge clk) disable iff (rst)
    wb_cyc |-> !cmd_ready);

  p_sel_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    wb_cyc |-> (wb_sel != '0));

  p_busy_rsp_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> busy);
endmodule

bind bwb_bridge bwb_bridge_chk #(
  .WB_ADR_W (WB_ADR_W),
  .DATA_W   (DATA_W),
  .LANES    (LANES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_ready (cmd_ready),
  .rsp_data  (rsp_data),
  .rsp_valid (rsp_valid),
  .rsp_last  (rsp_last),
  .rsp_ready (rsp_ready),
  .wb_adr    (wb_adr),
  .wb_dat_o  (wb_dat_o),
  .wb_we     (wb_we),
  .wb_sel    (wb_sel),
  .wb_stb    (wb_stb),
  .wb_cyc    (wb_cyc),
  .wb_ack    (wb_ack),
  .busy      (busy)
);

// File: tb/bwb_bridge_bench.sv
module bwb_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] HI = 32'h5A00_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cmd_data = 8'h00;
  logic        cmd_valid = 1'b0;
  logic        cmd_last = 1'b0;
  logic        cmd_ready;
  logic [7:0]  rsp_data;
  logic        rsp_valid;
  logic        rsp_last;
  logic        rsp_ready = 1'b0;
  logic [29:0] wb_adr;
  logic [31:0] wb_dat_o;
  logic [31:0] wb_dat_i;
  logic        wb_we;
  logic [3:0]  wb_sel;
  logic        wb_stb;
  logic        wb_cyc;
  logic        wb_ack;
  logic        busy;

  always #(CLK_PERIOD/2) clk = ~clk;

  bwb_bridge u_bwb_bridge (
    .clk(clk), .rst(rst),
    .cmd_data(cmd_data), .cmd_valid(cmd_valid), .cmd_last(cmd_last), .cmd_ready(cmd_ready),
    .rsp_data(rsp_data), .rsp_valid(rsp_valid), .rsp_last(rsp_last), .rsp_ready(rsp_ready),
    .wb_adr(wb_adr), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i), .wb_we(wb_we),
    .wb_sel(wb_sel), .wb_stb(wb_stb), .wb_cyc(wb_cyc), .wb_ack(wb_ack), .busy(busy)
  );

  // bus RAM model, ack one cycle after the request
  logic [31:0] ram [0:255];
  int wr_cycles = 0, rd_cycles = 0, rd_selbits = 0;
  bit adr_hi_bad = 0, cyc_ready_bad = 0;

  always @(posedge clk) begin
    if (rst) begin
      wb_ack   <= 1'b0;
      wb_dat_i <= '0;
      for (int w = 0; w < 256; w++)
        for (int k = 0; k < 4; k++)
          ram[w][8*k +: 8] <= 8'((w*4 + k) * 13 + 7);
    end else begin
      wb_ack <= wb_cyc && wb_stb && !wb_ack;
      if (wb_cyc && cmd_ready) cyc_ready_bad <= 1;
      if (wb_cyc && wb_stb && !wb_ack) begin
        if (wb_adr[29:8] != HI[31:10]) adr_hi_bad <= 1;
        if (wb_we) begin
          wr_cycles <= wr_cycles + 1;
          for (int k = 0; k < 4; k++)
            if (wb_sel[k]) ram[wb_adr[7:0]][8*k +: 8] <= wb_dat_o[8*k +: 8];
        end else begin
          rd_cycles  <= rd_cycles + 1;
          rd_selbits <= rd_selbits + $countones(wb_sel);
          wb_dat_i   <= ram[wb_adr[7:0]];
        end
      end
    end
  end

  // response sink with pseudo-random back-pressure
  logic [15:0] lfsr = 16'hACE1;
  logic [8:0]  got_q[$];
  logic [8:0]  exp_q[$];
  bit stall_prev = 0, hold_bad = 0, busy_bad = 0;
  logic [8:0] held;

  always @(negedge clk) begin
    logic r;
    if (stall_prev && !(rsp_valid && {rsp_last, rsp_data} == held)) hold_bad = 1;
    if (rsp_valid && !busy) busy_bad = 1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    r = lfsr[0] | lfsr[3];
    rsp_ready = r;
    if (rsp_valid && r) got_q.push_back({rsp_last, rsp_data});
    stall_prev = rsp_valid && !r;
    held = {rsp_last, rsp_data};
  end

  int n_chk = 0, n_bad = 0;
  logic [7:0] sh [0:1023];
  logic [7:0] fr[$];
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit l);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_data = b; cmd_last = l;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    #1;
    cmd_valid = 1'b0; cmd_last = 1'b0;
  endtask

  task automatic send_fr();
    for (int i = 0; i < fr.size(); i++) send_byte(fr[i], i == fr.size() - 1);
  endtask

  task automatic mk_req(input logic [7:0] op, input logic [31:0] a, input logic [15:0] c);
    fr.delete();
    fr.push_back(op);
    for (int i = 3; i >= 0; i--) fr.push_back(a[8*i +: 8]);
    fr.push_back(c[15:8]);
    fr.push_back(c[7:0]);
  endtask

  task automatic exp_hdr(input logic [7:0] op, input logic [31:0] a, input logic [15:0] c,
                         input bit last_end);
    exp_q.push_back({1'b0, op});
    for (int i = 3; i >= 0; i--) exp_q.push_back({1'b0, a[8*i +: 8]});
    exp_q.push_back({1'b0, c[15:8]});
    exp_q.push_back({last_end, c[7:0]});
  endtask

  task automatic settle();
    repeat (100) @(negedge clk);
  endtask

  task automatic check_rsp(input string tag);
    bit ok = (got_q.size() == exp_q.size());
    int bad_i = -1;
    if (ok)
      for (int i = 0; i < exp_q.size(); i++)
        if (got_q[i] !== exp_q[i] && bad_i < 0) begin ok = 0; bad_i = i; end
    if (!ok && bad_i >= 0)
      chk(0, tag, "response byte {last,data}", 64'(got_q[bad_i]), 64'(exp_q[bad_i]));
    else
      chk(ok, tag, "response length", 64'(got_q.size()), 64'(exp_q.size()));
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic check_mem(input string tag);
    int bad_a = -1;
    for (int a = 0; a < 1024; a++)
      if (ram[a >> 2][8*(a & 3) +: 8] !== sh[a] && bad_a < 0) bad_a = a;
    if (bad_a >= 0)
      chk(0, tag, $sformatf("memory byte at %0d", bad_a),
          64'(ram[bad_a >> 2][8*(bad_a & 3) +: 8]), 64'(sh[bad_a]));
    else
      chk(1, tag, "memory", 0, 0);
  endtask

  function automatic logic [7:0] wdat(input int len, input int off, input int i);
    return 8'((len * 16 + off * 4 + i) * 37 + 5);
  endfunction

  initial begin
    int w0, r0, s0;
    logic [31:0] a;
    for (int b = 0; b < 1024; b++) sh[b] = 8'(b * 13 + 7);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state (R11, R12)
    chk(busy == 1'b0, "R11", "busy after reset", 64'(busy), 0);
    chk(rsp_valid == 1'b0 && wb_cyc == 1'b0, "R12", "valid/cyc after reset",
        64'({rsp_valid, wb_cyc}), 0);
    chk(cmd_ready == 1'b1, "R12", "cmd_ready after reset", 64'(cmd_ready), 1);

    // write sweep: lanes 0..3, counts 1..9 (R1 R2 R4 R5)
    for (int len = 1; len <= 9; len++)
      for (int off = 0; off < 4; off++) begin
        a = HI | 32'(32 * len + 8 + off);
        w0 = wr_cycles;
        mk_req(8'hA2, a, 16'(len));
        for (int i = 0; i < len; i++) begin
          fr.push_back(wdat(len, off, i));
          sh[(a[9:0] + i) & 1023] = wdat(len, off, i);
        end
        send_fr();
        exp_hdr(8'hA4, a, 16'(len), 1'b1);
        settle();
        check_rsp("R2/R1 write response");
        check_mem("R5 write bytes");
        chk(wr_cycles - w0 == (off + len + 3) / 4, "R5", "write cycles",
            64'(wr_cycles - w0), 64'((off + len + 3) / 4));
      end

    // read sweep (R3 R4 R6)
    for (int len = 1; len <= 9; len++)
      for (int off = 0; off < 4; off++) begin
        a = HI | 32'(32 * len + 8 + off);
        r0 = rd_cycles; s0 = rd_selbits;
        mk_req(8'hA1, a, 16'(len));
        send_fr();
        exp_hdr(8'hA3, a, 16'(len), 1'b0);
        for (int i = 0; i < len; i++)
          exp_q.push_back({i == len - 1, sh[(a[9:0] + i) & 1023]});
        settle();
        check_rsp("R3/R4 read response");
        chk(rd_cycles - r0 == (off + len + 3) / 4, "R6", "read cycles",
            64'(rd_cycles - r0), 64'((off + len + 3) / 4));
        chk(rd_selbits - s0 == len, "R6", "read select bits",
            64'(rd_selbits - s0), 64'(len));
      end

    // bad first byte: leading zeros, then a response opcode (R7)
    w0 = wr_cycles; r0 = rd_cycles;
    fr.delete(); fr.push_back(8'h00); fr.push_back(8'h00);
    begin
      logic [7:0] tmp[$];
      mk_req(8'hA2, HI | 32'd500, 16'd2);
      tmp = fr;
      fr.delete(); fr.push_back(8'h00); fr.push_back(8'h00);
      for (int i = 0; i < tmp.size(); i++) fr.push_back(tmp[i]);
    end
    fr.push_back(8'h11); fr.push_back(8'h22);
    send_fr();
    mk_req(8'hA3, HI | 32'd500, 16'd1);
    send_fr();
    settle();
    check_rsp("R7 ignored frames");
    check_mem("R7 memory untouched");
    chk(wr_cycles == w0 && rd_cycles == r0, "R7", "bus cycles",
        64'(wr_cycles - w0 + rd_cycles - r0), 0);

    // trailing padding (R8)
    a = HI | 32'd700;
    mk_req(8'hA2, a, 16'd2);
    fr.push_back(8'h5C); fr.push_back(8'hC5);
    fr.push_back(8'h00); fr.push_back(8'h00); fr.push_back(8'h00);
    sh[700] = 8'h5C; sh[701] = 8'hC5;
    send_fr();
    exp_hdr(8'hA4, a, 16'd2, 1'b1);
    mk_req(8'hA1, a, 16'd2);
    fr.push_back(8'hA2); fr.push_back(8'h00);
    send_fr();
    exp_hdr(8'hA3, a, 16'd2, 1'b0);
    exp_q.push_back({1'b0, 8'h5C}); exp_q.push_back({1'b1, 8'hC5});
    settle();
    check_rsp("R8 padded requests");
    check_mem("R8 padded write");

    // truncation in header and in write data (R9)
    w0 = wr_cycles;
    fr.delete(); fr.push_back(8'hA2); fr.push_back(8'h5A); fr.push_back(8'h00);
    send_fr();
    fr.delete(); fr.push_back(8'hA1);
    send_fr();
    a = HI | 32'd600;
    mk_req(8'hA2, a, 16'd6);
    for (int i = 0; i < 5; i++) fr.push_back(8'hE0 + 8'(i));
    for (int i = 0; i < 4; i++) sh[600 + i] = 8'hE0 + 8'(i);
    send_fr();
    settle();
    check_rsp("R9 truncated frames");
    check_mem("R9 only full word kept");
    chk(wr_cycles - w0 == 1, "R9", "write cycles", 64'(wr_cycles - w0), 1);
    chk(busy == 1'b0, "R9", "busy after abort", 64'(busy), 0);

    // zero count (R10)
    w0 = wr_cycles; r0 = rd_cycles;
    mk_req(8'hA2, HI | 32'd44, 16'd0);
    send_fr();
    exp_hdr(8'hA4, HI | 32'd44, 16'd0, 1'b1);
    mk_req(8'hA1, HI | 32'd45, 16'd0);
    send_fr();
    exp_hdr(8'hA3, HI | 32'd45, 16'd0, 1'b1);
    settle();
    check_rsp("R10 zero count responses");
    chk(wr_cycles == w0 && rd_cycles == r0, "R10", "bus cycles",
        64'(wr_cycles - w0 + rd_cycles - r0), 0);

    // busy in mid frame (R11)
    a = HI | 32'd701;
    mk_req(8'hA1, a, 16'd1);
    send_byte(fr[0], 0); send_byte(fr[1], 0); send_byte(fr[2], 0);
    @(negedge clk);
    chk(busy == 1'b1, "R11", "busy mid frame", 64'(busy), 1);
    for (int i = 3; i < 7; i++) send_byte(fr[i], i == 6);
    exp_hdr(8'hA3, a, 16'd1, 1'b0);
    exp_q.push_back({1'b1, sh[701]});
    settle();
    check_rsp("R11 read after busy probe");
    chk(busy == 1'b0, "R11", "busy when done", 64'(busy), 0);
    chk(!busy_bad, "R11", "valid without busy", 64'(busy_bad), 0);

    chk(!adr_hi_bad, "R4", "upper word address bits", 64'(adr_hi_bad), 0);
    chk(!cyc_ready_bad, "R12", "cmd_ready during cycle", 64'(cyc_ready_bad), 0);
    chk(!hold_bad, "R13", "response held under stall", 64'(hold_bad), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule